// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is an I2C target that fronts a small byte-addressed register memory. It watches the SCL and SDA lines through a two-stage synchronizer and picks out START, repeated START and STOP from them. It compares the first byte after a START with a 7-bit device address set by a parameter, and it answers on SDA through an active-high pull-down output. The bus itself is wired-AND, so a 1 on the pull-down output holds the line low.

Writes carry a two-byte address, high byte first. Up to one page of data bytes may follow. These bytes go into a page buffer and reach the memory only after a STOP, during an internal busy window in which the device address is not acknowledged. An address pointer survives between transactions. It serves reads at the current address, random reads (a write header with no data, then a repeated START and a read header) and sequential reads that wrap around the whole array. A write-protect input stops data bytes from being accepted.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, the SDA pull-down is released, every memory byte reads 0x00 and the address pointer is 0.
- R2: After a START, the first byte is seven address bits (MSB first) and then the R/W bit (1 = read). The block pulls SDA low in the ninth clock only when the address bits equal `DEV_ADDR`. On a mismatch it leaves SDA released until the next START.
- R3: A write header (R/W = 0) is followed by two address bytes, high byte first. Each is acknowledged. The pointer is loaded with the low `ADDR_W` bits of the 16-bit value.
- R4: Each acknowledged data byte is buffered at the pointer. After each one, only the low `PAGE_W` pointer bits advance, wrapping inside the page. The buffered bytes are written to memory after a STOP that follows at least one acknowledged data byte.
- R5: A repeated START after buffered data discards that data, and memory keeps its old contents.
- R6: For `BUSY_CYC` clocks after a committing STOP, a matching device address is not acknowledged.
- R7: After a read header is acknowledged, the block sends the byte at the pointer, MSB first, pulling SDA low for each 0 bit, and releases SDA in the acknowledge slot. A master ACK (SDA low) starts the next byte. A master NACK ends the read, with SDA released.
- R8: Each byte sent increments the pointer across the whole array, so address 2^ADDR_W-1 is followed by 0. A current-address read starts at the byte after the last one accessed.
- R9: A write header with an address and no data loads the pointer, writes nothing and starts no busy window.
- R10: While `wp_i` is high at the end of a data byte, that byte gets no acknowledge and is not buffered. The address bytes are still acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND result) |
| wp_i | input | 1 | Write protect, 1 blocks data bytes |
| sda_pd_o | output | 1 | SDA pull-down, 1 drives the line low |

## Verification
Every SDA answer from the block (an acknowledge, a data bit or a release) appears on the third clock after the SCL falling edge that calls for it: two synchronizer stages and one state register. The bench therefore keeps each SCL low phase at eight clocks. It compares the pull-down output with the reference model on every clock, from the fourth clock after a falling edge up to the next falling edge, and it reads the wired-AND line in the middle of the high phase, as a master would. A committed write becomes visible only after the busy window, so the bench waits `BUSY_CYC` plus a margin before it reads the data back. It probes the busy window itself with a header issued right after the STOP.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DEV,
        ST_AHI,
        ST_ACK_AHI,
        ST_ALO,
        ST_ACK_ALO,
        ST_WDAT,
        ST_ACK_WDAT,
        ST_RDAT,
        ST_RACK,
        ST_IGNORE
    } ctl_state_e;

endpackage

// File: rtl/i2cm_bus_sense.sv
module i2cm_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop,
    output logic sda_s
);
    logic [1:0] scl_m_q, sda_m_q;
    logic       scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m_q <= 2'b11;
            sda_m_q <= 2'b11;
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_m_q <= {scl_m_q[0], scl_i};
            sda_m_q <= {sda_m_q[0], sda_i};
            scl_p_q <= scl_m_q[1];
            sda_p_q <= sda_m_q[1];
        end
    end

    assign sda_s    = sda_m_q[1];
    assign scl_rise = scl_m_q[1] & ~scl_p_q;
    assign scl_fall = ~scl_m_q[1] & scl_p_q;
    assign ev_start = scl_m_q[1] & scl_p_q & sda_p_q & ~sda_m_q[1];
    assign ev_stop  = scl_m_q[1] & scl_p_q & ~sda_p_q & sda_m_q[1];

endmodule

// File: rtl/i2cm_mem_bank.sv
module i2cm_mem_bank #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= 8'h00;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/i2cm_page_buf.sv
module i2cm_page_buf #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [PAGE_W-1:0] widx,
    input  logic [7:0]        wdata,
    input  logic [PAGE_W-1:0] ridx,
    output logic [7:0]        rdata,
    output logic              rvalid,
    output logic              any_valid
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [7:0]       slot_q [SLOTS];
    logic [SLOTS-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   vld_q <= '0;
        else if (clr) vld_q <= '0;
        else if (wr)  vld_q[widx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr) slot_q[widx] <= wdata;
    end

    assign rdata     = slot_q[ridx];
    assign rvalid    = vld_q[ridx];
    assign any_valid = |vld_q;

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         ADDR_W   = 8,
    parameter int         PAGE_W   = 6,
    parameter int         BUSY_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_pd_o
);
    import i2cm_pkg::*;

    localparam int BUSY_W = $clog2(BUSY_CYC + 1);
    localparam int HI_W   = ADDR_W - PAGE_W;

    typedef struct packed {
        ctl_state_e        state;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [7:0]        ahi;
        logic [ADDR_W-1:0] ptr;
        logic              rw;
        logic              mack;
        logic              pd;
        logic [BUSY_W-1:0] busy_cnt;
        logic              cact;
        logic [PAGE_W-1:0] cidx;
    } regs_t;

    regs_t q, d;

    logic scl_rise, scl_fall, ev_start, ev_stop, sda_s;
    logic buf_wr, buf_clr, buf_rvalid, buf_any;
    logic [7:0] buf_rdata, mem_rdata;
    logic mem_we;
    logic busy;
    ctl_state_e cur_state;

    i2cm_bus_sense u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .sda_s    (sda_s)
    );

    i2cm_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .wr        (buf_wr),
        .widx      (q.ptr[PAGE_W-1:0]),
        .wdata     (q.sh),
        .ridx      (q.cidx),
        .rdata     (buf_rdata),
        .rvalid    (buf_rvalid),
        .any_valid (buf_any)
    );

    i2cm_mem_bank #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr ({q.ptr[ADDR_W-1:PAGE_W], q.cidx}),
        .wdata (buf_rdata),
        .raddr (q.ptr),
        .rdata (mem_rdata)
    );

    assign busy      = (q.busy_cnt != '0);
    assign cur_state = q.state;
    assign sda_pd_o  = q.pd;

    always_comb begin
        d       = q;
        buf_wr  = 1'b0;
        buf_clr = 1'b0;
        mem_we  = 1'b0;

        if (busy) d.busy_cnt = q.busy_cnt - BUSY_W'(1);

        // walk the page buffer, one slot per clock
        if (q.cact) begin
            mem_we = buf_rvalid;
            d.cidx = q.cidx + PAGE_W'(1);
            if (&q.cidx) begin
                d.cact  = 1'b0;
                buf_clr = 1'b1;
            end
        end

        if (ev_start) begin
            d.state = ST_DEV;
            d.cnt   = 4'd0;
            d.pd    = 1'b0;
            if (!q.cact) buf_clr = 1'b1;
        end else if (ev_stop) begin
            d.state = ST_IDLE;
            d.pd    = 1'b0;
            if (buf_any && !q.cact) begin
                d.cact     = 1'b1;
                d.cidx     = '0;
                d.busy_cnt = BUSY_W'(BUSY_CYC);
            end
        end else if (scl_rise) begin
            case (q.state)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    d.sh  = {q.sh[6:0], sda_s};
                    d.cnt = q.cnt + 4'd1;
                end
                ST_RACK: d.mack = ~sda_s;
                default: ;
            endcase
        end else if (scl_fall) begin
            case (q.state)
                ST_DEV: begin
                    if (q.cnt == 4'd8) begin
                        if (q.sh[7:1] == DEV_ADDR && !busy) begin
                            d.state = ST_ACK_DEV;
                            d.pd    = 1'b1;
                            d.rw    = q.sh[0];
                        end else begin
                            d.state = ST_IGNORE;
                            d.pd    = 1'b0;
                        end
                    end
                end
                ST_ACK_DEV: begin
                    if (q.rw) begin
                        d.sh    = mem_rdata;
                        d.pd    = ~mem_rdata[7];
                        d.cnt   = 4'd1;
                        d.state = ST_RDAT;
                    end else begin
                        d.pd    = 1'b0;
                        d.cnt   = 4'd0;
                        d.state = ST_AHI;
                    end
                end
                ST_AHI: begin
                    if (q.cnt == 4'd8) begin
                        d.ahi   = q.sh;
                        d.pd    = 1'b1;
                        d.state = ST_ACK_AHI;
                    end
                end
                ST_ACK_AHI: begin
                    d.pd    = 1'b0;
                    d.cnt   = 4'd0;
                    d.state = ST_ALO;
                end
                ST_ALO: begin
                    if (q.cnt == 4'd8) begin
                        d.ptr   = ADDR_W'({q.ahi, q.sh});
                        d.pd    = 1'b1;
                        d.state = ST_ACK_ALO;
                    end
                end
                ST_ACK_ALO: begin
                    d.pd    = 1'b0;
                    d.cnt   = 4'd0;
                    d.state = ST_WDAT;
                end
                ST_WDAT: begin
                    if (q.cnt == 4'd8) begin
                        d.state = ST_ACK_WDAT;
                        if (!wp_i) begin
                            buf_wr = 1'b1;
                            d.pd   = 1'b1;
                            d.ptr  = {q.ptr[ADDR_W-1 -: HI_W],
                                      q.ptr[PAGE_W-1:0] + PAGE_W'(1)};
                        end else begin
                            d.pd = 1'b0;
                        end
                    end
                end
                ST_ACK_WDAT: begin
                    d.pd    = 1'b0;
                    d.cnt   = 4'd0;
                    d.state = ST_WDAT;
                end
                ST_RDAT: begin
                    if (q.cnt == 4'd8) begin
                        d.pd    = 1'b0;
                        d.ptr   = q.ptr + ADDR_W'(1);
                        d.state = ST_RACK;
                    end else begin
                        d.pd  = ~q.sh[3'd7 - q.cnt[2:0]];
                        d.cnt = q.cnt + 4'd1;
                    end
                end
                ST_RACK: begin
                    if (q.mack) begin
                        d.sh    = mem_rdata;
                        d.pd    = ~mem_rdata[7];
                        d.cnt   = 4'd1;
                        d.state = ST_RDAT;
                    end else begin
                        d.pd    = 1'b0;
                        d.state = ST_IGNORE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk #(
    parameter int ADDR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_i,
    input logic                 sda_pd_o,
    input i2cm_pkg::ctl_state_e cur_state,
    input logic                 busy,
    input logic                 mem_we,
    input logic [ADDR_W-1:0]    ptr
);
    import i2cm_pkg::*;

    AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IGNORE) |-> !sda_pd_o); // R2

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_state == ST_ACK_DEV) |-> !sda_pd_o); // R6

    AST_COMMIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R4

    AST_PD_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pd_o) |-> !scl_i); // R7

    AST_PTR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE && $past(cur_state == ST_IDLE)) |-> $stable(ptr)); // R8

endmodule

bind i2c_mem_target i2c_mem_target_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_pd_o  (sda_pd_o),
    .cur_state (cur_state),
    .busy      (busy),
    .mem_we    (mem_we),
    .ptr       (q.ptr)
);

// File: tb/i2c_mem_target_tb.sv
module i2c_mem_target_tb;
    localparam int         CLK_PERIOD = 10;
    localparam logic [6:0] DEV        = 7'h50;
    localparam int         AW         = 8;
    localparam int         PW         = 6;
    localparam int         BUSY       = 300;
    localparam int         DEPTH      = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
    logic pd;
    logic sda_bus;

    assign sda_bus = sda_m & ~pd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_mem_target #(.DEV_ADDR(DEV), .ADDR_W(AW), .PAGE_W(PW), .BUSY_CYC(BUSY)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .wp_i     (wp),
        .sda_pd_o (pd)
    );

    int    n_run = 0, n_fail = 0;
    logic  cmp_en = 1'b0, exp_pd = 1'b0;
    string cur_req = "R1";
    logic [7:0] mdl [DEPTH];
    int    ptr = 0;
    int    pend_a[$];
    int    pend_d[$];

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // per-clock comparison against the expected pull-down
    always @(negedge clk) begin
        if (cmp_en) check(pd === exp_pd, cur_req, "sda_pd per clock", int'(pd), int'(exp_pd));
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic phase_bit(input logic mb, input logic epd, output logic seen);
        cmp_en = 1'b0;
        tick(2); sda_m = mb;
        tick(2); exp_pd = epd; cmp_en = 1'b1;
        tick(4); scl = 1'b1;
        tick(4); seen = sda_bus;
        tick(4); scl = 1'b0; cmp_en = 1'b0;
    endtask

    task automatic bus_start();
        cmp_en = 1'b0;
        tick(4); exp_pd = 1'b0; cmp_en = 1'b1; sda_m = 1'b1;
        tick(2); scl = 1'b1;
        tick(4); sda_m = 1'b0;
        tick(4); scl = 1'b0; cmp_en = 1'b0;
    endtask

    task automatic bus_stop();
        cmp_en = 1'b0;
        tick(2); sda_m = 1'b0;
        tick(2); exp_pd = 1'b0; cmp_en = 1'b1; scl = 1'b1;
        tick(4); sda_m = 1'b1;
        tick(4); cmp_en = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic eack, input string req);
        logic seen;
        cur_req = req;
        for (int i = 7; i >= 0; i--) phase_bit(b[i], 1'b0, seen);
        phase_bit(1'b1, eack, seen);
        check(seen === ~eack, req, "ack slot level", int'(seen), int'(~eack));
    endtask

    task automatic recv_byte(input logic [7:0] expv, input logic mack, input string req);
        logic seen;
        logic [7:0] got;
        cur_req = req;
        for (int i = 7; i >= 0; i--) begin
            phase_bit(1'b1, ~expv[i], seen);
            got[i] = seen;
        end
        phase_bit(~mack, 1'b0, seen);
        check(got === expv, req, "read byte", int'(got), int'(expv));
    endtask

    function automatic int page_next(input int a);
        return (a & ~((1 << PW) - 1)) | ((a + 1) & ((1 << PW) - 1));
    endfunction

    // full write; optional wait for the busy window
    task automatic m_write(input int addr, input logic [7:0] dat [4], input int n,
                           input bit wait_busy);
        pend_a.delete(); pend_d.delete();
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R2");
        send_byte(8'(addr >> 8), 1'b1, "R3");
        send_byte(8'(addr), 1'b1, "R3");
        ptr = addr % DEPTH;
        for (int k = 0; k < n; k++) begin
            send_byte(dat[k], ~wp, wp ? "R10" : "R4");
            if (!wp) begin
                pend_a.push_back(ptr); pend_d.push_back(int'(dat[k]));
                ptr = page_next(ptr);
            end
        end
        bus_stop();
        foreach (pend_a[k]) mdl[pend_a[k]] = 8'(pend_d[k]);
        if (wait_busy && pend_a.size() != 0) tick(BUSY + 100);
    endtask

    task automatic read_seq(input int n, input string req);
        bus_start();
        send_byte({DEV, 1'b1}, 1'b1, "R2");
        for (int k = 0; k < n; k++) begin
            recv_byte(mdl[ptr], k != n - 1, req);
            ptr = (ptr + 1) % DEPTH;
        end
        bus_stop();
    endtask

    task automatic m_read_rand(input int addr, input int n, input string req);
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R9");
        send_byte(8'(addr >> 8), 1'b1, "R9");
        send_byte(8'(addr), 1'b1, "R9");
        ptr = addr % DEPTH;
        cur_req = "R9";
        read_seq(n, req);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
        tick(5); rst_n = 1'b1; tick(5);

        // R1: reset state at the port and in the array
        check(pd === 1'b0, "R1", "pull-down after reset", int'(pd), 0);
        read_seq(1, "R1");

        // R3 R4: single byte, read back after busy window
        m_write(16'h0010, '{8'hA5, 8'h00, 8'h00, 8'h00}, 1, 1'b1);
        m_read_rand(16'h0010, 1, "R4");
        check(mdl[16'h10] === 8'hA5, "R4", "model byte", int'(mdl[16'h10]), 'hA5);

        // R2: foreign device address is ignored
        bus_start();
        send_byte({7'h23, 1'b0}, 1'b0, "R2");
        send_byte(8'h00, 1'b0, "R2");
        bus_stop();
        read_seq(1, "R8");

        // R4: page write wraps within its page
        m_write(16'h003E, '{8'h11, 8'h22, 8'h33, 8'h44}, 4, 1'b1);
        m_read_rand(16'h003E, 4, "R4");
        m_read_rand(16'h0000, 2, "R4");
        read_seq(1, "R8");

        // R6: device address refused during the busy window
        m_write(16'h0050, '{8'hC3, 8'h00, 8'h00, 8'h00}, 1, 1'b0);
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, "R6");
        bus_stop();
        tick(BUSY + 100);
        m_read_rand(16'h0050, 1, "R6");

        // R8: sequential read wraps the whole array
        m_write(16'h00FF, '{8'h77, 8'h00, 8'h00, 8'h00}, 1, 1'b1);
        m_read_rand(16'h00FF, 3, "R8");
        read_seq(2, "R8");

        // R10: write protect refuses data, no busy window follows
        wp = 1'b1;
        m_write(16'h0020, '{8'h5A, 8'h6B, 8'h00, 8'h00}, 2, 1'b0);
        m_read_rand(16'h0020, 1, "R10");
        wp = 1'b0;

        // R5: repeated START drops buffered data
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R5");
        send_byte(8'h00, 1'b1, "R5");
        send_byte(8'h30, 1'b1, "R5");
        send_byte(8'h99, 1'b1, "R5");
        ptr = page_next(16'h30);
        read_seq(1, "R5");
        m_read_rand(16'h0030, 1, "R5");
        check(mdl[16'h30] === 8'h00, "R5", "model byte", int'(mdl[16'h30]), 0);

        // R9: address-only write loads pointer, no busy, no change
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R9");
        send_byte(8'h00, 1'b1, "R9");
        send_byte(8'h10, 1'b1, "R9");
        bus_stop();
        ptr = 16'h10;
        read_seq(1, "R9");

        tick(10);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule